// File: doc/BRIEF.md
# Banked Interrupt-Distributor Control Register

This block holds the global control word of an interrupt distributor. It keeps three group enables, a secure/non-secure affinity-routing pair and a one-way flag that turns off the two-state security model. Every access carries a secure attribute. What a write may change, and what a read shows, depend on that attribute and on the flag. Once the flag is set, the secure-only fields are cleared and stay locked until reset.

A second, read-only identification word reports the number of interrupt lines and a set of fixed capability bits. Its security-support bit follows the flag. All other offsets read as zero and ignore writes, and no access is ever refused.

Requests use a valid/ready handshake. `req_ready` is held high, so the block never applies back-pressure and accepts a request in every cycle in which `req_valid` is high. A read answers with a one-cycle `rsp_valid` pulse in the cycle after acceptance. The response cannot be stalled, so the requester must take it in that cycle. Writes produce no response. The group enables and the flag are also driven out as plain level outputs.

Top module: `intd_ctl_bank`

## Requirements
- R1: After reset the control word at offset 0x00 reads 0x0000_0030: bits 4 and 5 are 1 and all other bits are 0. `grp0_en`, `grp1ns_en`, `grp1s_en` and `sec_disabled` are all 0.
- R2: While the flag (bit 6) is 0, a secure write to offset 0x00 sets bits 0, 1 and 2 from the write data. Those bits drive `grp0_en`, `grp1ns_en` and `grp1s_en`. Bits 3, 4, 5 and 7 to 31 of the write data have no effect.
- R3: While the flag is 0, a non-secure write to offset 0x00 changes only bit 1. Bits 0, 2 and 6 are left unchanged.
- R4: While the flag is 0, a non-secure read of offset 0x00 returns bit 1 and bit 4 (which reads 1). All other bits read 0, including bit 31.
- R5: A secure write with data bit 6 set, made while the flag is 0, sets the flag. The same write forces bit 2 and bit 5 to 0, whatever data bit 2 holds. `sec_disabled` rises in the cycle after the write.
- R6: Once set, the flag cannot be cleared by any write. Only reset returns it to 0.
- R7: While the flag is 1, any write to offset 0x00, secure or not, changes only bits 0 and 1. Bit 2 stays 0. Reads of either security return the full word.
- R8: The identification word at offset 0x04 reads as follows: bits 25 and 24 are 1, bits 23:19 are 0xF, bit 10 is 1 only while the flag is 0, and bits 4:0 are (NUM_IRQ-32)/32-1. All other bits are 0.
- R9: Writes to offset 0x04 change nothing. Any offset other than 0x00 and 0x04 reads 0 and its writes change nothing.
- R10: `req_ready` is always 1. `rsp_valid` is 1 exactly in the cycle after an accepted read and 0 otherwise. `rsp_rdata` reflects the state as it was when the read was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Secure access attribute |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 32 | Read data |
| grp0_en | output | 1 | Group 0 enable |
| grp1ns_en | output | 1 | Non-secure group 1 enable |
| grp1s_en | output | 1 | Secure group 1 enable |
| sec_disabled | output | 1 | Security model disabled flag |

## Verification
The two functions that can act in one cycle are the masked field update and the side effect of setting the flag. A single secure write carrying data bits 6 and 2 both asks for the secure group-1 enable and clears it. The bench sends that directed write and reads the word back. Bit 2 and bit 5 must be 0 and bit 6 must be 1, and the identification bit 10 must drop at the same time. Random traffic after the flag is set then checks that the lock holds and that only bits 0 and 1 stay writable.

// File: rtl/intd_ctl_pkg.sv
package intd_ctl_pkg;
  localparam int unsigned B_G0    = 0;
  localparam int unsigned B_G1NS  = 1;
  localparam int unsigned B_G1S   = 2;
  localparam int unsigned B_AR_S  = 4;
  localparam int unsigned B_AR_NS = 5;
  localparam int unsigned B_DS    = 6;
  localparam int unsigned DATA_W  = 32;

  typedef struct packed {
    logic g0;
    logic g1ns;
    logic g1s;
    logic ar_ns;
    logic ds;
  } ctl_state_t;
endpackage

// File: rtl/intd_ctl_state.sv
module intd_ctl_state
  import intd_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_secure,
  input  logic       d_g0,
  input  logic       d_g1ns,
  input  logic       d_g1s,
  input  logic       d_ds,
  output ctl_state_t st
);
  ctl_state_t nxt;

  always_comb begin
    nxt = st;
    if (wr_en) begin
      if (st.ds) begin
        nxt.g0   = d_g0;
        nxt.g1ns = d_g1ns;
      end else if (wr_secure) begin
        nxt.g0   = d_g0;
        nxt.g1ns = d_g1ns;
        nxt.g1s  = d_g1s;
        if (d_ds) begin
          nxt.ds    = 1'b1;
          nxt.g1s   = 1'b0;
          nxt.ar_ns = 1'b0;
        end
      end else begin
        nxt.g1ns = d_g1ns;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '{g0: 1'b0, g1ns: 1'b0, g1s: 1'b0, ar_ns: 1'b1, ds: 1'b0};
    end else begin
      st <= nxt;
    end
  end
endmodule

// File: rtl/intd_ctl_readmux.sv
module intd_ctl_readmux
  import intd_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_IRQ = 96
) (
  input  ctl_state_t          st,
  input  logic                rd_secure,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] TYPE_OFS = ADDR_W'(4);
  localparam int unsigned LINES_W = 5;

  logic [LINES_W-1:0] lines_field;

  generate
    if (NUM_IRQ <= 32) begin : g_no_ext
      assign lines_field = '0;
    end else begin : g_ext
      assign lines_field = LINES_W'((NUM_IRQ - 32) / 32 - 1);
    end
  endgenerate

  logic [DATA_W-1:0] full_view, ns_view, type_word;

  always_comb begin
    full_view          = '0;
    full_view[B_G0]    = st.g0;
    full_view[B_G1NS]  = st.g1ns;
    full_view[B_G1S]   = st.g1s;
    full_view[B_AR_S]  = 1'b1;
    full_view[B_AR_NS] = st.ar_ns;
    full_view[B_DS]    = st.ds;

    ns_view            = '0;
    ns_view[B_G1NS]    = st.g1ns;
    ns_view[B_AR_S]    = 1'b1;

    type_word          = '0;
    type_word[25]      = 1'b1;
    type_word[24]      = 1'b1;
    type_word[23:19]   = 5'hF;
    type_word[10]      = ~st.ds;
    type_word[LINES_W-1:0] = lines_field;

    if (rd_addr == CTRL_OFS)
      rd_data = (!st.ds && !rd_secure) ? ns_view : full_view;
    else if (rd_addr == TYPE_OFS)
      rd_data = type_word;
    else
      rd_data = '0;
  end
endmodule

// File: rtl/intd_ctl_bank.sv
module intd_ctl_bank
  import intd_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_IRQ = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              grp0_en,
  output logic              grp1ns_en,
  output logic              grp1s_en,
  output logic              sec_disabled
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);

  ctl_state_t        st;
  logic              ctl_wr;
  logic              rd_fire;
  logic [DATA_W-1:0] rd_word;
  logic              unused_wbits;

  assign req_ready    = 1'b1;
  assign ctl_wr       = req_valid && req_write && (req_addr == CTRL_OFS);
  assign rd_fire      = req_valid && !req_write;
  assign unused_wbits = ^{req_wdata[31:7], req_wdata[5:3]};

  intd_ctl_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctl_wr),
    .wr_secure (req_secure),
    .d_g0      (req_wdata[B_G0]),
    .d_g1ns    (req_wdata[B_G1NS]),
    .d_g1s     (req_wdata[B_G1S]),
    .d_ds      (req_wdata[B_DS]),
    .st        (st)
  );

  intd_ctl_readmux #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_rmux (
    .st        (st),
    .rd_secure (req_secure),
    .rd_addr   (req_addr),
    .rd_data   (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= rd_word;
    end
  end

  assign grp0_en      = st.g0;
  assign grp1ns_en    = st.g1ns;
  assign grp1s_en     = st.g1s;
  assign sec_disabled = st.ds;
endmodule

// File: rtl/intd_ctl_chk.sv
module intd_ctl_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_secure,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              grp0_en,
  input logic              grp1s_en,
  input logic              sec_disabled
);
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) req_ready);

  p_rsp_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_disabled |=> sec_disabled);

  p_flag_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_disabled) |-> !grp1s_en);

  p_locked_g1s_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_disabled |-> !grp1s_en);

  p_ns_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_secure && !sec_disabled && req_addr == '0)
      |=> ($stable(grp0_en) && $stable(grp1s_en) && !sec_disabled));
endmodule

bind intd_ctl_bank intd_ctl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_secure   (req_secure),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .grp0_en      (grp0_en),
  .grp1s_en     (grp1s_en),
  .sec_disabled (sec_disabled)
);

// File: tb/test_intd_ctl_bank.sv
module test_intd_ctl_bank;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned NUM_IRQ = 96;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic              req_secure = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              grp0_en, grp1ns_en, grp1s_en, sec_disabled;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the stored state
  bit m_g0, m_g1ns, m_g1s, m_arns, m_ds;

  always #4 clk = ~clk;

  intd_ctl_bank #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) i_intd_ctl_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .grp0_en(grp0_en), .grp1ns_en(grp1ns_en), .grp1s_en(grp1s_en),
    .sec_disabled(sec_disabled)
  );

  function automatic void model_reset();
    m_g0 = 0; m_g1ns = 0; m_g1s = 0; m_arns = 1; m_ds = 0;
  endfunction

  function automatic void model_write(logic [ADDR_W-1:0] a, logic [31:0] d, bit sec);
    if (a != 0) return;
    if (m_ds) begin
      m_g0 = d[0]; m_g1ns = d[1];
    end else if (sec) begin
      m_g0 = d[0]; m_g1ns = d[1]; m_g1s = d[2];
      if (d[6]) begin m_ds = 1; m_g1s = 0; m_arns = 0; end
    end else begin
      m_g1ns = d[1];
    end
  endfunction

  function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a, bit sec);
    logic [31:0] v = '0;
    if (a == 0) begin
      if (!m_ds && !sec) begin
        v[1] = m_g1ns; v[4] = 1'b1;
      end else begin
        v[0] = m_g0; v[1] = m_g1ns; v[2] = m_g1s; v[4] = 1'b1;
        v[5] = m_arns; v[6] = m_ds;
      end
    end else if (a == 4) begin
      v = 32'h0378_0000;
      v[10] = ~m_ds;
      v[4:0] = 5'((NUM_IRQ - 32) / 32 - 1);
    end
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check(tag, {28'd0, grp0_en, grp1ns_en, grp1s_en, sec_disabled},
          {28'd0, m_g0, m_g1ns, m_g1s, m_ds});
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [31:0] d, bit sec);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_secure = sec; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    model_write(a, d, sec);
    check("R10 no rsp after write", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, bit sec, string tag);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_secure = sec; req_addr = a;
    e = exp_read(a, sec);
    @(negedge clk);
    req_valid = 0;
    check("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check(tag, rsp_rdata, e);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  function automatic logic [ADDR_W-1:0] pick_addr(int unsigned r);
    case (r % 4)
      0, 1: return ADDR_W'(0);
      2:    return ADDR_W'(4);
      default: return ADDR_W'(8 + 4 * (r % 50));
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check_outs("R1 outputs");
    do_read(0, 1, "R1 ctrl after reset");
    check("R1 ctrl value", rsp_rdata, 32'h30);
    do_read(4, 1, "R8 type word");

    // R2 secure write, ignored bits
    do_write(0, 32'hFFFF_FFB7, 1);
    check_outs("R2 outputs");
    do_read(0, 1, "R2 secure readback");
    // R3 non-secure write
    do_write(0, 32'h0000_0045, 0);
    check_outs("R3 outputs");
    do_read(0, 1, "R3 secure view");
    // R4 non-secure view
    do_write(0, 32'h7, 1);
    do_read(0, 0, "R4 ns view");
    check("R4 ns value", rsp_rdata, 32'h12);
    // R9 reserved and type writes
    do_write(4, 32'hFFFF_FFFF, 1);
    do_write(8'h40, 32'hFFFF_FFFF, 1);
    do_read(4, 0, "R9 type unchanged");
    do_read(8'h40, 1, "R9 reserved reads zero");
    do_read(0, 1, "R9 ctrl untouched");

    // random traffic with the flag bit held clear
    for (int i = 0; i < 300; i++) begin
      int unsigned r = $urandom;
      logic [ADDR_W-1:0] a = pick_addr($urandom);
      logic [31:0] d = $urandom & 32'hFFFF_FFBF;
      if (r[0]) begin do_write(a, d, r[1]); check_outs("R2 R3 random outputs"); end
      else do_read(a, r[1], "R4 R8 R9 random read");
    end

    // R5 flag set together with bit 2 request
    do_write(0, 32'h0000_0047, 1);
    check_outs("R5 outputs after flag");
    do_read(0, 1, "R5 readback");
    check("R5 value", rsp_rdata, 32'h53);
    do_read(4, 0, "R5 R8 type bit10 low");
    // R6 cannot clear
    do_write(0, 32'h0, 1);
    do_write(0, 32'h0, 0);
    check("R6 flag held", {31'd0, sec_disabled}, 32'd1);
    // R7 any access writes bits 0,1 only
    do_write(0, 32'hFFFF_FFFF, 0);
    check_outs("R7 ns write locked mode");
    do_read(0, 0, "R7 ns full view");

    for (int i = 0; i < 200; i++) begin
      int unsigned r = $urandom;
      logic [ADDR_W-1:0] a = pick_addr($urandom);
      logic [31:0] d = $urandom;
      if (r[0]) begin do_write(a, d, r[1]); check_outs("R6 R7 random outputs"); end
      else do_read(a, r[1], "R7 R8 random read");
    end

    // R6 reset clears the flag
    apply_reset();
    check_outs("R6 reset clears flag");
    do_read(0, 1, "R1 R6 ctrl after second reset");

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule